// File: doc/BRIEF.md
# Bidirectional Latched Serial-to-Parallel Driver

This block turns a serial bit stream into a wide parallel word for a printhead-style driver. Bits enter a shift register one per qualified rising clock edge. The register shifts either toward stage 0 or toward the last stage, and a run-time direction input picks which. Two bidirectional serial pins exchange roles with the direction. Each pin appears as separate input, output and output-enable signals. The pin that is not taking data in presents the last stage in the current direction, so several devices can be chained.

A latch bank sits between the register and the outputs. It is transparent while the latch enable is high and holds its contents while the enable is low. A final stage combines an active-low blanking input and a polarity input into four output modes: all outputs high, all outputs low, inverted latch data and true latch data. None of the latch, blanking or polarity controls touch the shift register. The design is synchronous to one free-running clock. A shift strobe stands in for the serial clock edge. The latch is built as a capture register with a bypass path. The capture register loads on every clock edge where the latch enable is high.

Top module: `lat_sipo_driver`

## Requirements
- R1: The shift register changes only on a rising clock edge with `shift_en` high, and it advances one stage per such edge. `latch_en`, `blank_n` and `pol` have no effect on its contents.
- R2: With `dir` = 0, every stage i takes the old value of stage i+1 and `sa_i` enters stage N-1. Shifting N bits b0 first gives stage k = bk.
- R3: With `dir` = 1, every stage i takes the old value of stage i-1 and `sb_i` enters stage 0. Shifting N bits b0 first gives stage N-1-k = bk.
- R4: While `latch_en` is high, the latch output equals the shift register in the same cycle. This includes the cycle right after a shift.
- R5: While `latch_en` is low, the latch output keeps the register value from the last clock edge at which `latch_en` was high, even when the register shifts.
- R6: With `blank_n` = 0 and `pol` = 0 (mode code 2'b00), every bit of `par_out` is 1.
- R7: With `blank_n` = 0 and `pol` = 1 (mode code 2'b01), every bit of `par_out` is 0.
- R8: With `blank_n` = 1 and `pol` = 0 (mode code 2'b10), `par_out[i]` is the inverse of latch bit i.
- R9: With `blank_n` = 1 and `pol` = 1 (mode code 2'b11), `par_out[i]` equals latch bit i.
- R10: With `dir` = 0, `sb_oe` = 1, `sa_oe` = 0 and `sb_o` shows stage 0. With `dir` = 1, `sa_oe` = 1, `sb_oe` = 0 and `sa_o` shows stage N-1. A disabled serial output drives 0.
- R11: A rising edge with `rst` high clears every register stage and every latch bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir | input | 1 | Shift direction: 0 shifts toward stage 0, 1 toward stage N-1 |
| shift_en | input | 1 | Shift strobe; one stage advance per edge while high |
| sa_i | input | 1 | Serial pin A input side (data in when dir = 0) |
| sa_o | output | 1 | Serial pin A output side (stage N-1 when dir = 1) |
| sa_oe | output | 1 | Serial pin A output enable |
| sb_i | input | 1 | Serial pin B input side (data in when dir = 1) |
| sb_o | output | 1 | Serial pin B output side (stage 0 when dir = 0) |
| sb_oe | output | 1 | Serial pin B output enable |
| latch_en | input | 1 | Latch enable, transparent while high |
| blank_n | input | 1 | Active-low blanking |
| pol | input | 1 | Output polarity select |
| par_out | output | N | Parallel outputs after the mode stage |

## Verification
Properties check the following on every cycle: the per-edge neighbour shift in both directions, the register holding while the strobe is low, reset clearing, the latch following the register while enabled and staying frozen while disabled, the four output-mode relations, and the pin-role swap with its enables. Some behaviour only the bench scenarios can show. One example is that a whole pattern shifted in one direction lands in the expected bit order. Another is that a latched word survives a full second shift. The bench also shows that toggling blanking and polarity during a shift leaves the final word intact, and that the cascade output replays an earlier word bit for bit.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

    typedef enum logic [1:0] {
        MODE_ALL_ON  = 2'b00,
        MODE_ALL_OFF = 2'b01,
        MODE_INVERT  = 2'b10,
        MODE_PASS    = 2'b11
    } out_mode_e;

    typedef enum logic {
        SHIFT_DOWN = 1'b0,
        SHIFT_UP   = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic dout;
        logic oe;
    } ser_drive_t;

    function automatic out_mode_e decode_mode(input logic blank_n, input logic pol);
        return out_mode_e'({blank_n, pol});
    endfunction

endpackage

// File: rtl/lsd_shift_reg.sv
module lsd_shift_reg
    import lsd_pkg::*;
#(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  shift_dir_e   dir,
    input  logic         din_dn,
    input  logic         din_up,
    output logic [N-1:0] q,
    output logic [N-1:0] d_next
);

    for (genvar i = 0; i < N; i++) begin : g_stage
        logic from_lo;
        logic from_hi;

        if (i == 0) begin : g_lo_end
            assign from_lo = din_up;
        end else begin : g_lo_mid
            assign from_lo = q[i-1];
        end

        if (i == N - 1) begin : g_hi_end
            assign from_hi = din_dn;
        end else begin : g_hi_mid
            assign from_hi = q[i+1];
        end

        always_comb begin
            if (!shift_en) begin
                d_next[i] = q[i];
            end else if (dir == SHIFT_UP) begin
                d_next[i] = from_lo;
            end else begin
                d_next[i] = from_hi;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= d_next;
        end
    end

endmodule

// File: rtl/lsd_latch_bank.sv
module lsd_latch_bank #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         le,
    input  logic [N-1:0] reg_q,
    input  logic [N-1:0] reg_next,
    output logic [N-1:0] lat
);

    logic [N-1:0] held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (le) begin
            held <= reg_next;
        end
    end

    // Open latch shows the live register; closed latch shows the captured word.
    assign lat = le ? reg_q : held;

endmodule

// File: rtl/lsd_out_stage.sv
module lsd_out_stage
    import lsd_pkg::*;
#(
    parameter int N = 64
) (
    input  out_mode_e    mode,
    input  logic [N-1:0] lat,
    output logic [N-1:0] drive
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_comb begin
            unique case (mode)
                MODE_ALL_ON:  drive[i] = 1'b1;
                MODE_ALL_OFF: drive[i] = 1'b0;
                MODE_INVERT:  drive[i] = ~lat[i];
                default:      drive[i] = lat[i];
            endcase
        end
    end

endmodule

// File: rtl/lsd_ser_port.sv
module lsd_ser_port
    import lsd_pkg::*;
(
    input  shift_dir_e dir,
    input  logic       stage_first,
    input  logic       stage_last,
    output ser_drive_t pin_a,
    output ser_drive_t pin_b
);

    always_comb begin
        pin_a = '{dout: 1'b0, oe: 1'b0};
        pin_b = '{dout: 1'b0, oe: 1'b0};
        if (dir == SHIFT_UP) begin
            pin_a = '{dout: stage_last, oe: 1'b1};
        end else begin
            pin_b = '{dout: stage_first, oe: 1'b1};
        end
    end

endmodule

// File: rtl/lat_sipo_driver.sv
module lat_sipo_driver
    import lsd_pkg::*;
#(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         dir,
    input  logic         shift_en,
    input  logic         sa_i,
    output logic         sa_o,
    output logic         sa_oe,
    input  logic         sb_i,
    output logic         sb_o,
    output logic         sb_oe,
    input  logic         latch_en,
    input  logic         blank_n,
    input  logic         pol,
    output logic [N-1:0] par_out
);

    shift_dir_e   dir_e;
    out_mode_e    mode;
    logic [N-1:0] sreg_q;
    logic [N-1:0] sreg_d;
    logic [N-1:0] lat_q;
    ser_drive_t   pa;
    ser_drive_t   pb;

    assign dir_e = shift_dir_e'(dir);
    assign mode  = decode_mode(blank_n, pol);

    lsd_shift_reg #(.N(N)) u_sreg (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .dir      (dir_e),
        .din_dn   (sa_i),
        .din_up   (sb_i),
        .q        (sreg_q),
        .d_next   (sreg_d)
    );

    lsd_latch_bank #(.N(N)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .le       (latch_en),
        .reg_q    (sreg_q),
        .reg_next (sreg_d),
        .lat      (lat_q)
    );

    lsd_out_stage #(.N(N)) u_out (
        .mode  (mode),
        .lat   (lat_q),
        .drive (par_out)
    );

    lsd_ser_port u_ser (
        .dir         (dir_e),
        .stage_first (sreg_q[0]),
        .stage_last  (sreg_q[N-1]),
        .pin_a       (pa),
        .pin_b       (pb)
    );

    assign sa_o  = pa.dout;
    assign sa_oe = pa.oe;
    assign sb_o  = pb.dout;
    assign sb_oe = pb.oe;

endmodule

// File: rtl/lsd_checker.sv
module lsd_checker #(
    parameter int N = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         dir,
    input logic         shift_en,
    input logic         sa_i,
    input logic         sb_i,
    input logic         sa_o,
    input logic         sb_o,
    input logic         sa_oe,
    input logic         sb_oe,
    input logic         latch_en,
    input logic         blank_n,
    input logic         pol,
    input logic [N-1:0] sreg_q,
    input logic [N-1:0] lat_q,
    input logic [N-1:0] par_out
);

    AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(sreg_q)); // R1

    AST_SHIFT_DOWN: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !dir) |=> (sreg_q == {$past(sa_i), $past(sreg_q[N-1:1])})); // R2

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
        (shift_en && dir) |=> (sreg_q == {$past(sreg_q[N-2:0]), $past(sb_i)})); // R3

    AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (rst)
        (latch_en && blank_n && pol) |-> (par_out == sreg_q)); // R4

    AST_LATCH_CLOSED: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && $past(!latch_en)) |-> $stable(lat_q)); // R5

    AST_ALL_ON: assert property (@(posedge clk) disable iff (rst)
        (!blank_n && !pol) |-> (&par_out)); // R6

    AST_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (!blank_n && pol) |-> (par_out == '0)); // R7

    AST_INVERT: assert property (@(posedge clk) disable iff (rst)
        (blank_n && !pol) |-> (par_out == ~lat_q)); // R8

    AST_PASS: assert property (@(posedge clk) disable iff (rst)
        (blank_n && pol) |-> (par_out == lat_q)); // R9

    AST_PIN_ROLE: assert property (@(posedge clk) disable iff (rst)
        dir ? (sa_oe && !sb_oe && sa_o == sreg_q[N-1] && !sb_o)
            : (sb_oe && !sa_oe && sb_o == sreg_q[0] && !sa_o)); // R10

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (sreg_q == '0 && lat_q == '0)); // R11

endmodule

bind lat_sipo_driver lsd_checker #(.N(N)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dir      (dir),
    .shift_en (shift_en),
    .sa_i     (sa_i),
    .sb_i     (sb_i),
    .sa_o     (sa_o),
    .sb_o     (sb_o),
    .sa_oe    (sa_oe),
    .sb_oe    (sb_oe),
    .latch_en (latch_en),
    .blank_n  (blank_n),
    .pol      (pol),
    .sreg_q   (sreg_q),
    .lat_q    (lat_q),
    .par_out  (par_out)
);

// File: tb/lat_sipo_driver_tb.sv
module lat_sipo_driver_tb;

    localparam int N = 64;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;

    // bit N = dir, bits N-1:0 = pattern
    localparam logic [N:0] VEC [NVEC] = '{
        {1'b0, 64'hA5C3_0FF0_1234_8001},
        {1'b1, 64'hA5C3_0FF0_1234_8001},
        {1'b0, 64'h8000_0000_0000_0001},
        {1'b1, 64'h0000_0000_0000_0003},
        {1'b0, 64'hFFFF_FFFF_0000_0000},
        {1'b1, 64'hDEAD_BEEF_CAFE_F00D}
    };

    logic clk = 1'b0;
    logic rst, dir, shift_en, sa_i, sb_i, latch_en, blank_n, pol;
    logic sa_o, sa_oe, sb_o, sb_oe;
    logic [N-1:0] par_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lat_sipo_driver #(.N(N)) u_dut (
        .clk(clk), .rst(rst), .dir(dir), .shift_en(shift_en),
        .sa_i(sa_i), .sa_o(sa_o), .sa_oe(sa_oe),
        .sb_i(sb_i), .sb_o(sb_o), .sb_oe(sb_oe),
        .latch_en(latch_en), .blank_n(blank_n), .pol(pol),
        .par_out(par_out)
    );

    function automatic logic [N-1:0] model_out(logic [N-1:0] lat, logic bn, logic p);
        if (!bn) return p ? '0 : '1;
        return p ? lat : ~lat;
    endfunction

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Shift a full word so that the register ends up equal to pat.
    task automatic shift_in(logic d, logic [N-1:0] pat, bit toggle_modes);
        dir = d;
        shift_en = 1'b1;
        for (int k = 0; k < N; k++) begin
            logic b;
            b = d ? pat[N-1-k] : pat[k];
            sa_i = d ? ~b : b;
            sb_i = d ? b : ~b;
            if (toggle_modes) begin
                blank_n = k[0];
                pol = k[1];
            end
            @(posedge clk);
            @(negedge clk);
        end
        shift_en = 1'b0;
    endtask

    task automatic pulse_latch();
        latch_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        latch_en = 1'b0;
    endtask

    string mode_tag [4] = '{"R6 all-on", "R7 all-off", "R8 invert", "R9 pass"};

    initial begin
        rst = 1'b1; dir = 1'b0; shift_en = 1'b0; sa_i = 1'b0; sb_i = 1'b0;
        latch_en = 1'b0; blank_n = 1'b1; pol = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 reset pass-mode outputs", par_out, '0);
        chk("R10 dir0 sb_oe", N'(sb_oe), N'(1));
        chk("R10 dir0 sa_oe", N'(sa_oe), N'(0));
        rst = 1'b0;
        @(negedge clk);

        // Table walk: shift each word, latch it, check all four modes.
        for (int e = 0; e < NVEC; e++) begin
            logic d;
            logic [N-1:0] pat;
            d = VEC[e][N];
            pat = VEC[e][N-1:0];
            shift_in(d, pat, 1'b0);
            pulse_latch();
            for (int m = 0; m < 4; m++) begin
                blank_n = m[1];
                pol = m[0];
                #1;
                chk({d ? "R3 " : "R2 ", mode_tag[m]}, par_out, model_out(pat, m[1], m[0]));
            end
        end

        // R5: latch closed while a new word is shifted in.
        begin
            logic [N-1:0] p1, p2;
            p1 = 64'h0123_4567_89AB_CDEF;
            p2 = 64'hF0F0_0F0F_3C3C_C3C3;
            blank_n = 1'b1; pol = 1'b1;
            shift_in(1'b0, p1, 1'b0);
            pulse_latch();
            // Cascade: during the next shift, sb_o replays p1 bit by bit (R10).
            dir = 1'b0;
            shift_en = 1'b1;
            for (int k = 0; k < N; k++) begin
                sa_i = p2[k];
                sb_i = 1'b1;
                if (k == 0 || k == 17 || k == N - 1)
                    chk("R10 dir0 cascade sb_o", N'(sb_o), N'(p1[k]));
                @(posedge clk);
                @(negedge clk);
            end
            shift_en = 1'b0;
            chk("R5 latch held during shift", par_out, p1);

            // R4: open latch shows the register right after a shift.
            latch_en = 1'b1;
            #1;
            chk("R4 transparent open", par_out, p2);
            dir = 1'b0; sa_i = 1'b1; shift_en = 1'b1;
            @(posedge clk);
            @(negedge clk);
            shift_en = 1'b0;
            chk("R4 transparent after shift", par_out, {1'b1, p2[N-1:1]});
            latch_en = 1'b0;
        end

        // R1: blanking/polarity toggling during a shift leaves the word intact.
        begin
            logic [N-1:0] p3;
            p3 = 64'h5A5A_1111_EEEE_A5A5;
            shift_in(1'b1, p3, 1'b1);
            // Idle edges with strobe low: register must not move.
            repeat (4) @(negedge clk);
            pulse_latch();
            blank_n = 1'b1; pol = 1'b1;
            #1;
            chk("R1 shift unaffected by controls", par_out, p3);

            // R10 dir1 role swap and cascade replay.
            dir = 1'b1;
            #1;
            chk("R10 dir1 sa_oe", N'(sa_oe), N'(1));
            chk("R10 dir1 sb_oe", N'(sb_oe), N'(0));
            chk("R10 dir1 sb_o idle low", N'(sb_o), N'(0));
            shift_en = 1'b1;
            for (int k = 0; k < 3; k++) begin
                sb_i = 1'b0;
                chk("R10 R3 dir1 cascade sa_o", N'(sa_o), N'(p3[N-1-k]));
                @(posedge clk);
                @(negedge clk);
            end
            shift_en = 1'b0;
        end

        // R11: reset after activity clears register and latch.
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        blank_n = 1'b1; pol = 1'b0;
        #1;
        chk("R11 reset invert outputs", par_out, '1);
        latch_en = 1'b1;
        pol = 1'b1;
        #1;
        chk("R11 reset register cleared", par_out, '0);
        latch_en = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule